// File: doc/BRIEF.md
# Macroblock Edge Wide Deblocking Filter

This block smooths the pixels on both sides of a macroblock boundary. It works on sixteen independent lanes at once. Each lane holds eight unsigned 8-bit pixels taken across the edge: four on the near side, `p3` (outermost) to `p0` (next to the edge), and four on the far side, `q0` (next to the edge) to `q3` (outermost). Three 8-bit controls are shared by all lanes: an edge limit, an interior limit and a variance threshold. The block returns new values for the six inner pixels, `p2` to `q2`. The outermost pair only takes part in the decision.

A lane is filtered only when its pixel steps look like a coding artifact rather than a real image edge. A filtered lane with high edge variance changes only the two pixels next to the edge, using the short correction. Every other filtered lane spreads a weighted correction over three pixels on each side. The weights are roughly 3/7, 2/7 and 1/7 of the step across the edge. Fetching the pixels and transposing them are left to the surrounding logic. The result is registered once, and a valid flag travels alongside it.

Top module: `wdf_mb_edge_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and all pixel outputs are 0 after that edge.
- R2: `out_valid` equals the `in_valid` of the previous cycle. The pixel outputs show the inputs of the previous cycle, filtered.
- R3: A lane is masked when any of |p3-p2|, |p2-p1|, |p1-p0|, |q1-q0|, |q2-q1|, |q3-q2| is greater than `int_lim`, or when |p0-q0| is greater than `edge_lim`. A masked lane outputs its six inner pixels unchanged.
- R4: A lane has high variance when max(|p1-p0|, |q1-q0|) is greater than `hev_thr`. Such a lane keeps p2, p1, q1 and q2 unchanged. Its new q0 is sat(sq0 - (sat(w+4)>>>3)) and its new p0 is sat(sp0 + (sat(w+3)>>>3)).
- R5: Pixels are converted to signed form with sX = X xor 0x80. The step is w = sat(sat(sat(sat(sp1-sq1)+d)+d)+d), where d = sat(sq0-sp0). w is forced to 0 in a masked lane. A lane without high variance uses a_k = sat((k*w+63)>>>7), with k = 27 for p0/q0, 18 for p1/q1 and 9 for p2/q2. It then sets P = sat(P + a_k) and Q = sat(Q - a_k), and converts the results back with xor 0x80.
- R6: Every sum, difference and tap amount saturates to the signed range -128..127, including for the most extreme pixel values.
- R7: The lanes are independent. Lane i uses bits [8i+7:8i] of every pixel bus, and a lane's result does not depend on the other lanes.
- R8: The comparisons are strict. A difference equal to `int_lim` or `edge_lim` does not mask the lane, and a difference equal to `hev_thr` does not give high variance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector is valid |
| edge_lim | input | 8 | Largest allowed step across the edge |
| int_lim | input | 8 | Largest allowed step inside one side |
| hev_thr | input | 8 | High-variance threshold |
| in_p3 | input | 128 | Outermost near-side pixel, one byte per lane |
| in_p2 | input | 128 | Near-side pixel 2 |
| in_p1 | input | 128 | Near-side pixel 1 |
| in_p0 | input | 128 | Near-side pixel next to the edge |
| in_q0 | input | 128 | Far-side pixel next to the edge |
| in_q1 | input | 128 | Far-side pixel 1 |
| in_q2 | input | 128 | Far-side pixel 2 |
| in_q3 | input | 128 | Outermost far-side pixel |
| out_valid | output | 1 | Output vector is valid |
| out_p2 | output | 128 | Filtered p2 |
| out_p1 | output | 128 | Filtered p1 |
| out_p0 | output | 128 | Filtered p0 |
| out_q0 | output | 128 | Filtered q0 |
| out_q1 | output | 128 | Filtered q1 |
| out_q2 | output | 128 | Filtered q2 |

## Verification
Gentle ramps with no high variance show that the three-tap wide path gives each pixel pair its own weight. Sharp inner steps with a low threshold confirm that only the pixel pair next to the edge moves. Lanes pushed just over the interior limit or the edge limit must come back unchanged, and lanes sitting exactly on each limit must still be filtered, which exposes any non-strict compare. Full-scale 0/255 patterns drive every saturation point. Vectors that mix lane categories, together with random near-smooth data, expose lane crosstalk and arithmetic slips against an integer model.

// File: rtl/wdf_pkg.sv
// Shared types and signed-byte helpers for the wide deblocking filter.
// Assumes 8-bit pixels; all signed arithmetic saturates to -128..127.
package wdf_pkg;

    localparam int PIX_W = 8;

    typedef logic signed [PIX_W-1:0] sbyte_t;

    // Eight pixels across one edge, outermost near side first
    typedef struct packed {
        logic [PIX_W-1:0] p3, p2, p1, p0, q0, q1, q2, q3;
    } win_t;

    // Six writable pixels of one lane
    typedef struct packed {
        logic [PIX_W-1:0] p2, p1, p0, q0, q1, q2;
    } upd_t;

    function automatic logic signed [15:0] widen(input sbyte_t a);
        return {{8{a[7]}}, a};
    endfunction

    function automatic sbyte_t clamp_s8(input logic signed [15:0] v);
        if (v > 16'sd127)       return 8'h7f;
        else if (v < -16'sd128) return 8'h80;
        else                    return v[7:0];
    endfunction

    function automatic sbyte_t sadd(input sbyte_t a, input sbyte_t b);
        return clamp_s8(widen(a) + widen(b));
    endfunction

    function automatic sbyte_t ssub(input sbyte_t a, input sbyte_t b);
        return clamp_s8(widen(a) - widen(b));
    endfunction

    function automatic sbyte_t to_s(input logic [PIX_W-1:0] u);
        return u ^ 8'h80;
    endfunction

    function automatic logic [PIX_W-1:0] to_u(input sbyte_t s);
        return s ^ 8'h80;
    endfunction

    function automatic logic [PIX_W-1:0] adiff(input logic [PIX_W-1:0] a,
                                               input logic [PIX_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/wdf_edge_detect.sv
// Decides per lane whether the edge is filtered and whether it shows high
// variance. Assumes unsigned pixels; all compares are strictly greater-than.
module wdf_edge_detect
    import wdf_pkg::*;
(
    input  win_t             win,
    input  logic [PIX_W-1:0] edge_lim,
    input  logic [PIX_W-1:0] int_lim,
    input  logic [PIX_W-1:0] hev_thr,
    output logic             filt_en,
    output logic             hev
);
    localparam int N_INT = 6;

    logic [PIX_W-1:0] step [N_INT];
    logic [PIX_W-1:0] int_max;
    logic [PIX_W-1:0] inner_max;
    logic [PIX_W-1:0] edge_step;

    // Absolute steps between neighbours inside each side
    always_comb begin
        step[0] = adiff(win.p3, win.p2);
        step[1] = adiff(win.p2, win.p1);
        step[2] = adiff(win.p1, win.p0);
        step[3] = adiff(win.q1, win.q0);
        step[4] = adiff(win.q2, win.q1);
        step[5] = adiff(win.q3, win.q2);
        edge_step = adiff(win.p0, win.q0);
    end

    // Largest interior step and largest step next to the edge
    always_comb begin
        int_max = '0;
        for (int i = 0; i < N_INT; i++)
            if (step[i] > int_max) int_max = step[i];
        inner_max = (step[2] > step[3]) ? step[2] : step[3];
    end

    // Final decisions
    always_comb begin
        filt_en = !((int_max > int_lim) || (edge_step > edge_lim));
        hev     = inner_max > hev_thr;
    end

endmodule

// File: rtl/wdf_tap.sv
// One weighted tap: amount = sat8((K*w + RND) >>> SHIFT) using a 16-bit
// signed product. Assumes K*|w| + RND stays inside 16 bits.
module wdf_tap
    import wdf_pkg::*;
#(
    parameter int K     = 9,
    parameter int RND   = 63,
    parameter int SHIFT = 7
) (
    input  sbyte_t w,
    output sbyte_t amt
);
    localparam logic signed [15:0] KS = 16'(K);
    localparam logic signed [15:0] RS = 16'(RND);

    logic signed [15:0] prod;
    logic signed [15:0] biased;

    // Multiply, add rounding, shift and saturate to a byte
    always_comb begin
        prod   = KS * widen(w);
        biased = prod + RS;
        amt    = clamp_s8(biased >>> SHIFT);
    end

endmodule

// File: rtl/wdf_lane.sv
// One filter lane. Builds the edge step w, then applies either the short
// two-pixel correction (high variance) or the three-tap weighted spread.
// Assumes w is already zero for masked lanes, which makes every tap zero.
module wdf_lane
    import wdf_pkg::*;
#(
    parameter int W_NEAR = 27,
    parameter int W_MID  = 18,
    parameter int W_FAR  = 9,
    parameter int RND    = 63,
    parameter int SHIFT  = 7
) (
    input  win_t             win,
    input  logic [PIX_W-1:0] edge_lim,
    input  logic [PIX_W-1:0] int_lim,
    input  logic [PIX_W-1:0] hev_thr,
    output upd_t             res
);
    localparam int TAPS = 3;
    localparam int WT [TAPS] = '{W_NEAR, W_MID, W_FAR};

    logic   filt_en, hev;
    sbyte_t sp2, sp1, sp0, sq0, sq1, sq2;
    sbyte_t outer, dstep, acc1, acc2, acc3, w;
    sbyte_t f_q, f_p;
    sbyte_t amt [TAPS];

    wdf_edge_detect u_det (
        .win      (win),
        .edge_lim (edge_lim),
        .int_lim  (int_lim),
        .hev_thr  (hev_thr),
        .filt_en  (filt_en),
        .hev      (hev)
    );

    // Convert to signed form and build the saturated edge step
    always_comb begin
        sp2   = to_s(win.p2);
        sp1   = to_s(win.p1);
        sp0   = to_s(win.p0);
        sq0   = to_s(win.q0);
        sq1   = to_s(win.q1);
        sq2   = to_s(win.q2);
        outer = ssub(sp1, sq1);
        dstep = ssub(sq0, sp0);
        acc1  = sadd(outer, dstep);
        acc2  = sadd(acc1, dstep);
        acc3  = sadd(acc2, dstep);
        w     = filt_en ? acc3 : '0;
    end

    // Short correction amounts, rounded differently on each side
    always_comb begin
        f_q = sadd(w, 8'sd4) >>> 3;
        f_p = sadd(w, 8'sd3) >>> 3;
    end

    // Weighted taps, nearest pixel pair first
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        wdf_tap #(.K(WT[k]), .RND(RND), .SHIFT(SHIFT)) u_tap (
            .w   (w),
            .amt (amt[k])
        );
    end

    // Choose the path and convert back to unsigned pixels
    always_comb begin
        res.p2 = win.p2;
        res.p1 = win.p1;
        res.p0 = win.p0;
        res.q0 = win.q0;
        res.q1 = win.q1;
        res.q2 = win.q2;
        if (hev) begin
            res.p0 = to_u(sadd(sp0, f_p));
            res.q0 = to_u(ssub(sq0, f_q));
        end else begin
            res.p0 = to_u(sadd(sp0, amt[0]));
            res.q0 = to_u(ssub(sq0, amt[0]));
            res.p1 = to_u(sadd(sp1, amt[1]));
            res.q1 = to_u(ssub(sq1, amt[1]));
            res.p2 = to_u(sadd(sp2, amt[2]));
            res.q2 = to_u(ssub(sq2, amt[2]));
        end
    end

endmodule

// File: rtl/wdf_mb_edge_filter.sv
// Top: LANES parallel wide deblocking lanes with one output register stage.
// Lane i occupies bits [8i+7:8i] of every pixel bus. Limits are shared.
module wdf_mb_edge_filter
    import wdf_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [PIX_W-1:0]       edge_lim,
    input  logic [PIX_W-1:0]       int_lim,
    input  logic [PIX_W-1:0]       hev_thr,
    input  logic [LANES*PIX_W-1:0] in_p3,
    input  logic [LANES*PIX_W-1:0] in_p2,
    input  logic [LANES*PIX_W-1:0] in_p1,
    input  logic [LANES*PIX_W-1:0] in_p0,
    input  logic [LANES*PIX_W-1:0] in_q0,
    input  logic [LANES*PIX_W-1:0] in_q1,
    input  logic [LANES*PIX_W-1:0] in_q2,
    input  logic [LANES*PIX_W-1:0] in_q3,
    output logic                   out_valid,
    output logic [LANES*PIX_W-1:0] out_p2,
    output logic [LANES*PIX_W-1:0] out_p1,
    output logic [LANES*PIX_W-1:0] out_p0,
    output logic [LANES*PIX_W-1:0] out_q0,
    output logic [LANES*PIX_W-1:0] out_q1,
    output logic [LANES*PIX_W-1:0] out_q2
);
    localparam int BUS_W = LANES * PIX_W;

    upd_t res [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        win_t win;

        // Gather this lane's window from the pixel buses
        always_comb begin
            win.p3 = in_p3[i*PIX_W +: PIX_W];
            win.p2 = in_p2[i*PIX_W +: PIX_W];
            win.p1 = in_p1[i*PIX_W +: PIX_W];
            win.p0 = in_p0[i*PIX_W +: PIX_W];
            win.q0 = in_q0[i*PIX_W +: PIX_W];
            win.q1 = in_q1[i*PIX_W +: PIX_W];
            win.q2 = in_q2[i*PIX_W +: PIX_W];
            win.q3 = in_q3[i*PIX_W +: PIX_W];
        end

        wdf_lane u_lane (
            .win      (win),
            .edge_lim (edge_lim),
            .int_lim  (int_lim),
            .hev_thr  (hev_thr),
            .res      (res[i])
        );

        // Output register for this lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_p2[i*PIX_W +: PIX_W] <= '0;
                out_p1[i*PIX_W +: PIX_W] <= '0;
                out_p0[i*PIX_W +: PIX_W] <= '0;
                out_q0[i*PIX_W +: PIX_W] <= '0;
                out_q1[i*PIX_W +: PIX_W] <= '0;
                out_q2[i*PIX_W +: PIX_W] <= '0;
            end else begin
                out_p2[i*PIX_W +: PIX_W] <= res[i].p2;
                out_p1[i*PIX_W +: PIX_W] <= res[i].p1;
                out_p0[i*PIX_W +: PIX_W] <= res[i].p0;
                out_q0[i*PIX_W +: PIX_W] <= res[i].q0;
                out_q1[i*PIX_W +: PIX_W] <= res[i].q1;
                out_q2[i*PIX_W +: PIX_W] <= res[i].q2;
            end
        end
    end

    // Valid flag travels with the data
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    logic [BUS_W-1:0] unused_bus;
    assign unused_bus = '0;

endmodule

// File: rtl/wdf_mb_edge_filter_chk.sv
// Assertion checker for wdf_mb_edge_filter. It keeps its own copy of the
// previous inputs and its own lane classification, then relates them to
// the registered outputs.
module wdf_mb_edge_filter_chk #(
    parameter int LANES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [7:0]           edge_lim,
    input logic [7:0]           int_lim,
    input logic [7:0]           hev_thr,
    input logic [LANES*8-1:0]   in_p3,
    input logic [LANES*8-1:0]   in_p2,
    input logic [LANES*8-1:0]   in_p1,
    input logic [LANES*8-1:0]   in_p0,
    input logic [LANES*8-1:0]   in_q0,
    input logic [LANES*8-1:0]   in_q1,
    input logic [LANES*8-1:0]   in_q2,
    input logic [LANES*8-1:0]   in_q3,
    input logic                 out_valid,
    input logic [LANES*8-1:0]   out_p2,
    input logic [LANES*8-1:0]   out_p1,
    input logic [LANES*8-1:0]   out_p0,
    input logic [LANES*8-1:0]   out_q0,
    input logic [LANES*8-1:0]   out_q1,
    input logic [LANES*8-1:0]   out_q2
);
    logic armed, vin_q;

    // Armed once the previous edge was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            vin_q <= 1'b0;
        end else begin
            armed <= 1'b1;
            vin_q <= in_valid;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_p0 == '0 && out_q0 == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == vin_q));

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        logic [7:0] p3, p2, p1, p0, q0, q1, q2, q3;
        logic [7:0] rp2, rp1, rp0, rq0, rq1, rq2;
        logic       masked_q, hev_q;
        int         mx, hv;

        always_comb begin
            p3 = in_p3[i*8 +: 8]; p2 = in_p2[i*8 +: 8];
            p1 = in_p1[i*8 +: 8]; p0 = in_p0[i*8 +: 8];
            q0 = in_q0[i*8 +: 8]; q1 = in_q1[i*8 +: 8];
            q2 = in_q2[i*8 +: 8]; q3 = in_q3[i*8 +: 8];
            hv = (p1 > p0) ? int'(p1 - p0) : int'(p0 - p1);
            if (((q1 > q0) ? int'(q1 - q0) : int'(q0 - q1)) > hv)
                hv = (q1 > q0) ? int'(q1 - q0) : int'(q0 - q1);
            mx = hv;
            if (((p3 > p2) ? int'(p3 - p2) : int'(p2 - p3)) > mx) mx = (p3 > p2) ? int'(p3 - p2) : int'(p2 - p3);
            if (((p2 > p1) ? int'(p2 - p1) : int'(p1 - p2)) > mx) mx = (p2 > p1) ? int'(p2 - p1) : int'(p1 - p2);
            if (((q2 > q1) ? int'(q2 - q1) : int'(q1 - q2)) > mx) mx = (q2 > q1) ? int'(q2 - q1) : int'(q1 - q2);
            if (((q3 > q2) ? int'(q3 - q2) : int'(q2 - q3)) > mx) mx = (q3 > q2) ? int'(q3 - q2) : int'(q2 - q3);
        end

        // Remember this lane's inputs and class for the next cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                {rp2, rp1, rp0, rq0, rq1, rq2} <= '0;
                masked_q <= 1'b0;
                hev_q    <= 1'b0;
            end else begin
                {rp2, rp1, rp0, rq0, rq1, rq2} <= {p2, p1, p0, q0, q1, q2};
                masked_q <= (mx > int'(int_lim)) ||
                            (((p0 > q0) ? int'(p0 - q0) : int'(q0 - p0)) > int'(edge_lim));
                hev_q    <= hv > int'(hev_thr);
            end
        end

        a_r3_masked_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && masked_q) |->
            (out_p2[i*8 +: 8] == rp2 && out_p1[i*8 +: 8] == rp1 &&
             out_p0[i*8 +: 8] == rp0 && out_q0[i*8 +: 8] == rq0 &&
             out_q1[i*8 +: 8] == rq1 && out_q2[i*8 +: 8] == rq2));

        a_r4_hev_outer_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && hev_q) |->
            (out_p2[i*8 +: 8] == rp2 && out_p1[i*8 +: 8] == rp1 &&
             out_q1[i*8 +: 8] == rq1 && out_q2[i*8 +: 8] == rq2));

        a_r5_opposite_steps: assert property (@(posedge clk) disable iff (!rst_n)
            armed |->
            (!((out_p0[i*8 +: 8] > rp0) && (out_q0[i*8 +: 8] > rq0)) &&
             !((out_p0[i*8 +: 8] < rp0) && (out_q0[i*8 +: 8] < rq0))));
    end

endmodule

bind wdf_mb_edge_filter wdf_mb_edge_filter_chk #(.LANES(LANES)) i_chk (.*);

// File: tb/test_wdf_mb_edge_filter.sv
`timescale 1ns/1ps
module test_wdf_mb_edge_filter;
    localparam int LANES = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, in_valid;
    logic [7:0] edge_lim, int_lim, hev_thr;
    logic [LANES*8-1:0] in_p3, in_p2, in_p1, in_p0, in_q0, in_q1, in_q2, in_q3;
    logic out_valid;
    logic [LANES*8-1:0] out_p2, out_p1, out_p0, out_q0, out_q1, out_q2;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int px [LANES][8];   // index 0 = p3 ... 7 = q3

    wdf_mb_edge_filter #(.LANES(LANES)) i_wdf_mb_edge_filter (.*);

    function automatic int sc(input int v);
        return (v > 127) ? 127 : ((v < -128) ? -128 : v);
    endfunction

    function automatic int ad(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // Integer model of R3..R6, result order p2,p1,p0,q0,q1,q2
    task automatic model(input int l, output int e[6]);
        int v[8];
        int mx, hv, w, t, d, a;
        bit en, hev;
        int s[8];
        for (int j = 0; j < 8; j++) begin
            v[j] = px[l][j];
            s[j] = v[j] - 128;
        end
        hv = (ad(v[2], v[3]) > ad(v[5], v[4])) ? ad(v[2], v[3]) : ad(v[5], v[4]);
        mx = hv;
        if (ad(v[0], v[1]) > mx) mx = ad(v[0], v[1]);
        if (ad(v[1], v[2]) > mx) mx = ad(v[1], v[2]);
        if (ad(v[6], v[5]) > mx) mx = ad(v[6], v[5]);
        if (ad(v[7], v[6]) > mx) mx = ad(v[7], v[6]);
        en  = !(mx > int'(int_lim) || ad(v[3], v[4]) > int'(edge_lim));
        hev = hv > int'(hev_thr);
        t = sc(s[2] - s[5]);
        d = sc(s[4] - s[3]);
        w = sc(sc(sc(t + d) + d) + d);
        if (!en) w = 0;
        for (int j = 0; j < 6; j++) e[j] = s[j + 1];
        if (hev) begin
            e[3] = sc(s[4] - (sc(w + 4) >>> 3));
            e[2] = sc(s[3] + (sc(w + 3) >>> 3));
        end else begin
            a = sc((27 * w + 63) >>> 7); e[2] = sc(s[3] + a); e[3] = sc(s[4] - a);
            a = sc((18 * w + 63) >>> 7); e[1] = sc(s[2] + a); e[4] = sc(s[5] - a);
            a = sc((9 * w + 63) >>> 7);  e[0] = sc(s[1] + a); e[5] = sc(s[6] - a);
        end
        for (int j = 0; j < 6; j++) e[j] = e[j] + 128;
    endtask

    function automatic int get_out(input int l, input int j);
        case (j)
            0: return int'(out_p2[l*8 +: 8]);
            1: return int'(out_p1[l*8 +: 8]);
            2: return int'(out_p0[l*8 +: 8]);
            3: return int'(out_q0[l*8 +: 8]);
            4: return int'(out_q1[l*8 +: 8]);
            default: return int'(out_q2[l*8 +: 8]);
        endcase
    endfunction

    task automatic drive();
        for (int l = 0; l < LANES; l++) begin
            in_p3[l*8 +: 8] = 8'(px[l][0]); in_p2[l*8 +: 8] = 8'(px[l][1]);
            in_p1[l*8 +: 8] = 8'(px[l][2]); in_p0[l*8 +: 8] = 8'(px[l][3]);
            in_q0[l*8 +: 8] = 8'(px[l][4]); in_q1[l*8 +: 8] = 8'(px[l][5]);
            in_q2[l*8 +: 8] = 8'(px[l][6]); in_q3[l*8 +: 8] = 8'(px[l][7]);
        end
    endtask

    task automatic set_lane(input int l, input int a0, input int a1, input int a2,
                            input int a3, input int a4, input int a5, input int a6,
                            input int a7);
        px[l][0] = a0; px[l][1] = a1; px[l][2] = a2; px[l][3] = a3;
        px[l][4] = a4; px[l][5] = a5; px[l][6] = a6; px[l][7] = a7;
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next fall
    task automatic step();
        in_valid = 1'b1;
        drive();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_model(input string tag, input bit pass_only);
        int e[6];
        bit bad;
        for (int l = 0; l < LANES; l++) begin
            model(l, e);
            if (pass_only) for (int j = 0; j < 6; j++) e[j] = px[l][j + 1];
            bad = 0;
            for (int j = 0; j < 6; j++)
                if (get_out(l, j) != e[j]) begin
                    bad = 1;
                    $display("FAIL %s lane %0d pix %0d actual %0d expected %0d",
                             tag, l, j, get_out(l, j), e[j]);
                end
            checks++;
            if (bad) errors++;
        end
    endtask

    task automatic t_reset();
        checks++;
        if (out_valid !== 1'b0 || out_p0 !== '0 || out_q2 !== '0) begin
            errors++;
            $display("FAIL R1 actual valid=%b p0=%h expected 0", out_valid, out_p0);
        end
    endtask

    task automatic t_smooth();   // R5 wide path on gentle steps
        edge_lim = 60; int_lim = 40; hev_thr = 40;
        for (int l = 0; l < LANES; l++)
            set_lane(l, 40 + l, 44 + l, 48 + l, 52 + l, 52 + 3 * l, 55 + 3 * l, 58 + 3 * l, 60 + 3 * l);
        step();
        check_model("R5 smooth", 0);
        for (int l = 0; l < LANES; l++)
            set_lane(l, 200 - l, 196 - l, 190, 185, 160 + l, 158, 150, 148);
        step();
        check_model("R5 falling", 0);
    endtask

    task automatic t_hev();      // R4 narrow path
        edge_lim = 80; int_lim = 60; hev_thr = 5;
        for (int l = 0; l < LANES; l++)
            set_lane(l, 100, 100, 110 + l, 90, 130 - l, 120, 118, 118);
        step();
        check_model("R4 hev", 0);
    endtask

    task automatic t_mask();     // R3 both mask causes
        edge_lim = 30; int_lim = 10; hev_thr = 3;
        for (int l = 0; l < LANES; l++)
            set_lane(l, 50, 50 + 11 + l, 60 + l, 62 + l, 70 + l, 70 + l, 71 + l, 72 + l);
        step();
        check_model("R3 interior", 1);
        for (int l = 0; l < LANES; l++)
            set_lane(l, 20, 20, 21, 22, 22 + 31 + l, 53 + l, 53 + l, 53 + l);
        step();
        check_model("R3 edge", 1);
    endtask

    task automatic t_limits();   // R8 exactly on and one over each limit
        edge_lim = 20; int_lim = 8; hev_thr = 6;
        for (int l = 0; l < LANES; l++)
            if (l % 2 == 0) set_lane(l, 100, 108, 110, 104, 124, 130, 132, 124);
            else            set_lane(l, 100, 109, 110, 104, 125, 130, 132, 124);
        step();
        check_model("R8 boundary", 0);
        hev_thr = 5;
        step();
        check_model("R8 threshold", 0);
    endtask

    task automatic t_saturate(); // R6 extremes
        edge_lim = 255; int_lim = 255; hev_thr = 255;
        for (int l = 0; l < LANES; l++)
            case (l % 4)
                0: set_lane(l, 255, 255, 255, 0, 255, 0, 0, 0);
                1: set_lane(l, 0, 0, 0, 255, 0, 255, 255, 255);
                2: set_lane(l, 255, 255, 255, 248, 255, 0, 0, 0);
                default: set_lane(l, 0, 0, 0, 7, 0, 255, 255, 255);
            endcase
        step();
        check_model("R6 wide", 0);
        hev_thr = 0;
        step();
        check_model("R6 narrow", 0);
    endtask

    task automatic t_mixed();    // R7 different categories side by side
        edge_lim = 25; int_lim = 12; hev_thr = 6;
        for (int l = 0; l < LANES; l++)
            case (l % 4)
                0: set_lane(l, 80, 82, 84, 86, 100, 102, 104, 106);
                1: set_lane(l, 80, 82, 92, 86, 100, 108, 104, 106);
                2: set_lane(l, 80, 99, 84, 86, 100, 102, 104, 106);
                default: set_lane(l, 10, 12, 14, 16, 60, 62, 64, 66);
            endcase
        step();
        check_model("R7 mixed", 0);
    endtask

    task automatic t_valid();    // R2 valid pipeline
        bit pat[6] = '{1, 0, 1, 1, 0, 1};
        for (int k = 0; k < 6; k++) begin
            in_valid = pat[k];
            @(posedge clk);
            @(negedge clk);
            checks++;
            if (out_valid !== pat[k]) begin
                errors++;
                $display("FAIL R2 step %0d actual %b expected %b", k, out_valid, pat[k]);
            end
        end
    endtask

    task automatic t_random();   // R5 R7 random near-smooth data
        for (int n = 0; n < 150; n++) begin
            edge_lim = 8'($urandom_range(0, 80));
            int_lim  = 8'($urandom_range(0, 40));
            hev_thr  = 8'($urandom_range(0, 20));
            for (int l = 0; l < LANES; l++) begin
                int b = int'($urandom_range(0, 255));
                for (int j = 0; j < 8; j++) begin
                    int v = b + int'($urandom_range(0, 40)) - 20 + ((j >= 4) ? int'($urandom_range(0, 60)) - 30 : 0);
                    px[l][j] = (v < 0) ? 0 : ((v > 255) ? 255 : v);
                end
            end
            step();
            check_model("R5 R7 random", 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b1;
        edge_lim = '0; int_lim = '0; hev_thr = '0;
        for (int l = 0; l < LANES; l++) set_lane(l, 1, 2, 3, 4, 5, 6, 7, 8);
        drive();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_smooth();
        t_hev();
        t_mask();
        t_limits();
        t_saturate();
        t_mixed();
        t_valid();
        t_random();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule